// File: doc/BRIEF.md
# Comparator Output Conditioner

This block is the clocked digital back end of one analog comparator channel. The comparator's raw decision arrives asynchronously. It is brought into the peripheral clock domain by a short flop chain and may be inverted. It then passes through a glitch filter that needs a programmable number of consecutive identical samples before its output changes. The filter's sample rate can be slowed by a prescaler, which stretches the longest windows further. A select bit decides whether the output pin carries the unfiltered or the filtered level.

Transitions of the filtered level set a sticky interrupt flag. A two-bit polarity field picks which transitions count. The same events can also set a separate sticky wake-up flag. Software clears either flag by pulsing its clear strobe. The interrupt request is the flag qualified by an enable. Dropping the channel enable forces the outputs low and flushes the datapath. After the channel is re-enabled, the level it sees first is taken as the starting point and raises no event.

Top module: `cmpout_cond`

## Requirements
- R1: The raw comparator bit passes through a two-flop synchroniser. With the filter off and the pin set to unfiltered, a change of the raw bit appears on the pin after exactly two rising clock edges.
- R2: When the invert control is 1, the synchronised bit is complemented before the filter, the pin, the status bit and the edge detector see it.
- R3: Filter code 0 bypasses the filter. Codes 1 to 7 require 1, 2, 4, 8, 16, 32 or 64 consecutive sampled values that differ from the current filtered level before that level changes. A sample equal to the filtered level restarts the count, so a shorter pulse leaves the level unchanged.
- R4: The prescaler code selects one sample every 1, 2 or 4 clocks for codes 0, 1 and 2. Reserved code 3 behaves as 1. The prescaler acts only when the filter code is 7, giving windows of about 64, 128 or 256 clocks. At any other filter code it is ignored.
- R5: With the pin select at 0, the pin carries the unfiltered conditioned bit. With it at 1, the pin carries the filtered level.
- R6: Edge polarity 00 counts both edges of the filtered level, 01 counts rising edges only and 10 counts falling edges only. Reserved code 11 never counts an edge.
- R7: The interrupt flag is set one clock after a counted edge. It stays set until a clear strobe is sampled, and it is kept while the channel is disabled. When a set and a clear fall on the same edge, the set wins.
- R8: The interrupt request equals the interrupt flag while the interrupt enable is 1 and is 0 otherwise.
- R9: A counted edge also sets the wake-up flag when the wake enable is 1. That flag is sticky and has its own clear strobe, where a set also wins over a clear.
- R10: The status bit carries the filtered level and, like the pin, is 0 whenever the channel enable is 0. While the channel is disabled the synchroniser, the filter counters and the edge history are held cleared.
- R11: After the channel enable rises, the first valid synchronised level is adopted as the filtered level and as the edge history without counting an edge. Later changes are counted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous raw comparator decision |
| ch_en | input | 1 | Channel enable |
| inv_en | input | 1 | Invert the synchronised decision |
| filt_code | input | 3 | Filter length code (0 = off, n = 2^(n-1) samples) |
| fdiv_code | input | 2 | Sample prescaler code, used at filter code 7 only |
| pin_sel | input | 1 | Pin source: 0 unfiltered, 1 filtered |
| edge_pol | input | 2 | Counted edges: 00 both, 01 rise, 10 fall, 11 none |
| irq_en | input | 1 | Interrupt request enable |
| wake_en | input | 1 | Wake-up flag enable |
| clr_irq | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| clr_wake | input | 1 | Write-one-to-clear strobe for the wake-up flag |
| comp_status | output | 1 | Filtered level, 0 while disabled |
| pin_out | output | 1 | Selected pin level, 0 while disabled |
| irq_flag | output | 1 | Sticky interrupt flag |
| wake_flag | output | 1 | Sticky wake-up flag |
| irq | output | 1 | Interrupt request |

## Verification
A filter counter that does not restart, or a prescaler that acts at the wrong filter code, shows up as a status transition many clocks early or late. In the longest windows that is a difference of up to hundreds of cycles. The bench measures these latencies directly. Wrong edge history or a wrong warm-up sequence shows up one clock after the fault, as a flag set where none should be. Synchroniser or inversion faults reach the unfiltered pin within two clocks. The reference model, compared on every clock, catches each of these on the first cycle of divergence.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    localparam int CODE_W   = 3;
    localparam int DIV_W    = 2;
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int MAX_LEN  = 1 << (MAX_CODE - 1);
    localparam int CNT_W    = $clog2(MAX_LEN) + 1;
    localparam int PCNT_W   = 2;

    typedef enum logic [1:0] {
        POL_BOTH = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Number of consecutive differing samples needed for a change; 0 = bypass.
    function automatic logic [CNT_W-1:0] filt_len(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        if (code == '0) return '0;
        return one << (code - 1'b1);
    endfunction

    // Clocks per sample; the prescaler only applies at the longest code.
    function automatic logic [2:0] div_len(input logic [CODE_W-1:0] code,
                                           input logic [DIV_W-1:0]  fdiv);
        if (code != CODE_W'(MAX_CODE)) return 3'd1;
        case (fdiv)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic pol_hit(input pol_e pol, input edge_t e);
        case (pol)
            POL_BOTH: return e.rise | e.fall;
            POL_RISE: return e.rise;
            POL_FALL: return e.fall;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic dout,
    output logic adopt,
    output logic ready
);
    localparam int WARM_MAX = STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_MAX + 1);

    logic [STAGES-1:0] chain;
    logic [WARM_W-1:0] warm;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst || !en) chain <= '0;
                else            chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst || !en) chain <= '0;
                else            chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    // Counts the enabled cycles until the chain holds live data.
    always_ff @(posedge clk) begin
        if (rst || !en)                     warm <= '0;
        else if (warm != WARM_W'(WARM_MAX)) warm <= warm + 1'b1;
    end

    assign dout  = chain[STAGES-1];
    assign adopt = en && (warm == WARM_W'(STAGES));
    assign ready = en && (warm == WARM_W'(WARM_MAX));

endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter
    import cmpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              adopt,
    input  logic              ready,
    input  logic              sample,
    input  logic [CODE_W-1:0] code,
    input  logic [DIV_W-1:0]  fdiv,
    output logic              level,
    output logic [CNT_W-1:0]  cnt_o
);
    logic              held;
    logic [CNT_W-1:0]  cnt;
    logic [PCNT_W-1:0] pcnt;
    logic [2:0]        div;
    logic [CNT_W-1:0]  len;
    logic              tick;
    logic              reach;

    assign div   = div_len(code, fdiv);
    assign len   = filt_len(code);
    assign tick  = ready && ({1'b0, pcnt} >= (div - 3'd1));
    assign reach = ({1'b0, cnt} + 1'b1) >= {1'b0, len};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            held <= 1'b0;
            cnt  <= '0;
            pcnt <= '0;
        end else if (adopt) begin
            held <= sample;
            cnt  <= '0;
            pcnt <= '0;
        end else if (ready) begin
            pcnt <= tick ? '0 : pcnt + 1'b1;
            if (code == '0) begin
                held <= sample;
                cnt  <= '0;
            end else if (tick) begin
                if (sample != held) begin
                    if (reach) begin
                        held <= sample;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end
    end

    assign level = (code == '0) ? sample : held;
    assign cnt_o = cnt;

endmodule

// File: rtl/cmpc_edge.sv
module cmpc_edge
    import cmpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       adopt,
    input  logic       ready,
    input  logic       seed,
    input  logic       lvl,
    input  logic [1:0] pol,
    input  logic       wake_en,
    input  logic       clr_irq,
    input  logic       clr_wake,
    output logic       irq_flag,
    output logic       wake_flag,
    output logic       set_o
);
    logic  prev;
    edge_t ev;
    logic  hit;

    assign ev.rise = en && ready && lvl && !prev;
    assign ev.fall = en && ready && !lvl && prev;
    assign hit     = pol_hit(pol_e'(pol), ev);

    always_ff @(posedge clk) begin
        if (rst || !en) prev <= 1'b0;
        else if (adopt) prev <= seed;
        else            prev <= lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag  <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            if (hit)          irq_flag <= 1'b1;
            else if (clr_irq) irq_flag <= 1'b0;
            if (hit && wake_en) wake_flag <= 1'b1;
            else if (clr_wake)  wake_flag <= 1'b0;
        end
    end

    assign set_o = hit;

endmodule

// File: rtl/cmpout_cond.sv
module cmpout_cond
    import cmpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_raw,
    input  logic              ch_en,
    input  logic              inv_en,
    input  logic [CODE_W-1:0] filt_code,
    input  logic [DIV_W-1:0]  fdiv_code,
    input  logic              pin_sel,
    input  logic [1:0]        edge_pol,
    input  logic              irq_en,
    input  logic              wake_en,
    input  logic              clr_irq,
    input  logic              clr_wake,
    output logic              comp_status,
    output logic              pin_out,
    output logic              irq_flag,
    output logic              wake_flag,
    output logic              irq
);
    logic             sync_q;
    logic             sync_adopt;
    logic             sync_ready;
    logic             cond;
    logic             filt_lvl;
    logic [CNT_W-1:0] filt_cnt;
    logic             ev_set;

    cmpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .en    (ch_en),
        .din   (cmp_raw),
        .dout  (sync_q),
        .adopt (sync_adopt),
        .ready (sync_ready)
    );

    assign cond = sync_q ^ inv_en;

    cmpc_filter u_filt (
        .clk    (clk),
        .rst    (rst),
        .en     (ch_en),
        .adopt  (sync_adopt),
        .ready  (sync_ready),
        .sample (cond),
        .code   (filt_code),
        .fdiv   (fdiv_code),
        .level  (filt_lvl),
        .cnt_o  (filt_cnt)
    );

    cmpc_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .en        (ch_en),
        .adopt     (sync_adopt),
        .ready     (sync_ready),
        .seed      (cond),
        .lvl       (filt_lvl),
        .pol       (edge_pol),
        .wake_en   (wake_en),
        .clr_irq   (clr_irq),
        .clr_wake  (clr_wake),
        .irq_flag  (irq_flag),
        .wake_flag (wake_flag),
        .set_o     (ev_set)
    );

    assign comp_status = ch_en & filt_lvl;
    assign pin_out     = ch_en & (pin_sel ? filt_lvl : cond);
    assign irq         = irq_flag & irq_en;

endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker
    import cmpc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ch_en,
    input logic             irq_en,
    input logic             wake_en,
    input logic [1:0]       edge_pol,
    input logic             clr_irq,
    input logic             irq_flag,
    input logic             wake_flag,
    input logic             irq,
    input logic             ev_set,
    input logic             ready,
    input logic [CNT_W-1:0] fcnt
);
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_irq) |=> irq_flag);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ev_set |=> irq_flag);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_irq && !ev_set) |=> !irq_flag);

    assert_reserved_pol_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> ($past(edge_pol) != 2'b11));

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_en);

    assert_wake_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_flag) |-> $past(wake_en));

    assert_disable_flush_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(ch_en) |-> (fcnt == '0));

    assert_no_warmup_edge_R11: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !ev_set);

endmodule

bind cmpout_cond cmpc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ch_en     (ch_en),
    .irq_en    (irq_en),
    .wake_en   (wake_en),
    .edge_pol  (edge_pol),
    .clr_irq   (clr_irq),
    .irq_flag  (irq_flag),
    .wake_flag (wake_flag),
    .irq       (irq),
    .ev_set    (ev_set),
    .ready     (sync_ready),
    .fcnt      (filt_cnt)
);

// File: tb/sim_cmpout_cond.sv
`timescale 1ns/1ps
module sim_cmpout_cond;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_raw = 1'b0;
    logic       ch_en = 1'b0;
    logic       inv_en = 1'b0;
    logic [2:0] filt_code = 3'd0;
    logic [1:0] fdiv_code = 2'd0;
    logic       pin_sel = 1'b0;
    logic [1:0] edge_pol = 2'b00;
    logic       irq_en = 1'b0;
    logic       wake_en = 1'b0;
    logic       clr_irq = 1'b0;
    logic       clr_wake = 1'b0;
    logic       comp_status, pin_out, irq_flag, wake_flag, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cmpout_cond u0 (
        .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .ch_en(ch_en), .inv_en(inv_en),
        .filt_code(filt_code), .fdiv_code(fdiv_code), .pin_sel(pin_sel),
        .edge_pol(edge_pol), .irq_en(irq_en), .wake_en(wake_en),
        .clr_irq(clr_irq), .clr_wake(clr_wake), .comp_status(comp_status),
        .pin_out(pin_out), .irq_flag(irq_flag), .wake_flag(wake_flag), .irq(irq)
    );

    // Behavioural reference state
    bit m_s1, m_s2, m_fv, m_prev, m_if, m_wf;
    int m_w, m_cnt, m_pcnt;

    function automatic bit m_cond();
        return m_s2 ^ inv_en;
    endfunction

    function automatic bit m_filt();
        return (filt_code == 0) ? m_cond() : m_fv;
    endfunction

    always @(posedge clk) begin
        bit c, f, r, fl, hit;
        int div, need;
        bit tk;
        cycles++;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_fv = 0; m_prev = 0; m_if = 0; m_wf = 0;
            m_w = 0; m_cnt = 0; m_pcnt = 0;
        end else begin
            c = m_cond();
            f = m_filt();
            hit = 0;
            if (ch_en && m_w == 3) begin
                r  = f && !m_prev;
                fl = !f && m_prev;
                if (edge_pol == 2'b00) hit = r | fl;
                else if (edge_pol == 2'b01) hit = r;
                else if (edge_pol == 2'b10) hit = fl;
            end
            if (hit) m_if = 1; else if (clr_irq) m_if = 0;
            if (hit && wake_en) m_wf = 1; else if (clr_wake) m_wf = 0;
            if (!ch_en) begin
                m_s1 = 0; m_s2 = 0; m_w = 0; m_fv = 0; m_cnt = 0; m_pcnt = 0; m_prev = 0;
            end else begin
                if (m_w == 2) begin
                    m_fv = c; m_cnt = 0; m_pcnt = 0; m_prev = c;
                end else begin
                    m_prev = f;
                    if (m_w == 3) begin
                        div = 1;
                        if (filt_code == 7 && fdiv_code == 1) div = 2;
                        if (filt_code == 7 && fdiv_code == 2) div = 4;
                        tk = (m_pcnt >= div - 1);
                        m_pcnt = tk ? 0 : m_pcnt + 1;
                        if (filt_code == 0) begin
                            m_fv = c; m_cnt = 0;
                        end else if (tk) begin
                            need = 1 << (filt_code - 1);
                            if (c != m_fv) begin
                                if (m_cnt + 1 >= need) begin m_fv = c; m_cnt = 0; end
                                else m_cnt++;
                            end else m_cnt = 0;
                        end
                    end
                end
                m_s2 = m_s1;
                m_s1 = cmp_raw;
                if (m_w < 3) m_w++;
            end
        end
    end

    // Cycle compare, away from the active edge
    always @(negedge clk) begin
        bit e_st, e_pin, e_irq;
        if (!done) begin
            e_st  = ch_en & m_filt();
            e_pin = ch_en & (pin_sel ? m_filt() : m_cond());
            e_irq = m_if & irq_en;
            checks++;
            if (comp_status !== e_st || pin_out !== e_pin || irq_flag !== m_if ||
                wake_flag !== m_wf || irq !== e_irq) begin
                fails++;
                if (comp_status !== e_st)
                    $display("FAIL R10 status cyc %0d actual %0b expected %0b", cycles, comp_status, e_st);
                if (pin_out !== e_pin)
                    $display("FAIL R5 pin cyc %0d actual %0b expected %0b", cycles, pin_out, e_pin);
                if (irq_flag !== m_if)
                    $display("FAIL R7 irq_flag cyc %0d actual %0b expected %0b", cycles, irq_flag, m_if);
                if (wake_flag !== m_wf)
                    $display("FAIL R9 wake_flag cyc %0d actual %0b expected %0b", cycles, wake_flag, m_wf);
                if (irq !== e_irq)
                    $display("FAIL R8 irq cyc %0d actual %0b expected %0b", cycles, irq, e_irq);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (!done && cycles > 150000) begin
            done = 1;
            fails++;
            $display("FAIL watchdog R1 actual %0d cycles expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Edges from a raw change until the status shows the new level
    task automatic lat(input bit v, output int n);
        @(negedge clk);
        #1 cmp_raw = v;
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            n++;
            if (comp_status == v) break;
        end
        #1;
    endtask

    task automatic clear_flags();
        clr_irq = 1; clr_wake = 1;
        step(1);
        clr_irq = 0; clr_wake = 0;
        step(1);
    endtask

    initial begin
        int  n;
        bit  seen;
        step(3);
        chk(comp_status == 0 && pin_out == 0, "R10", "reset outputs", comp_status, 0);
        chk(irq_flag == 0 && irq == 0, "R7", "reset irq flag", irq_flag, 0);
        chk(wake_flag == 0, "R9", "reset wake flag", wake_flag, 0);
        rst = 0;
        ch_en = 1; irq_en = 1; wake_en = 1;
        step(6);

        // R1 synchroniser latency on the unfiltered path
        lat(1, n);
        chk(n == 2, "R1", "sync latency", n, 2);
        chk(pin_out == 1, "R5", "unfiltered pin", pin_out, 1);
        step(2);
        chk(irq_flag == 1, "R7", "flag after edge", irq_flag, 1);
        chk(wake_flag == 1, "R9", "wake flag after edge", wake_flag, 1);
        chk(irq == 1, "R8", "irq with enable", irq, 1);
        clear_flags();
        chk(irq_flag == 0, "R7", "flag cleared", irq_flag, 0);
        chk(wake_flag == 0, "R9", "wake cleared", wake_flag, 0);

        // R2 inversion
        inv_en = 1;
        step(4);
        chk(pin_out == 0, "R2", "inverted pin", pin_out, 0);
        chk(comp_status == 0, "R2", "inverted status", comp_status, 0);
        inv_en = 0;
        step(4);
        clear_flags();

        // R3 filter length and restart
        filt_code = 3;
        lat(0, n);
        chk(n == 6, "R3", "4-sample latency", n, 6);
        cmp_raw = 1; step(2); cmp_raw = 0; step(12);
        chk(comp_status == 0, "R3", "short pulse rejected", comp_status, 0);
        cmp_raw = 1; step(3); cmp_raw = 0; step(1); cmp_raw = 1; step(4);
        chk(comp_status == 0, "R3", "count restarts", comp_status, 0);
        step(4);
        chk(comp_status == 1, "R3", "level taken after full count", comp_status, 1);

        // R5 pin select
        pin_sel = 1;
        cmp_raw = 0; step(3);
        chk(pin_out == 1, "R5", "filtered pin holds", pin_out, 1);
        step(8);
        chk(pin_out == 0, "R5", "filtered pin follows", pin_out, 0);
        pin_sel = 0;

        // R4 prescaler
        filt_code = 5; fdiv_code = 2;
        lat(1, n);
        chk(n == 18, "R4", "prescaler ignored below max code", n, 18);
        filt_code = 7; fdiv_code = 0;
        lat(0, n);
        chk(n == 66, "R4", "64-sample latency", n, 66);
        fdiv_code = 1;
        lat(1, n);
        chk(n >= 129 && n <= 130, "R4", "div2 latency", n, 129);
        fdiv_code = 2;
        lat(0, n);
        chk(n >= 255 && n <= 258, "R4", "div4 latency", n, 256);
        fdiv_code = 3;
        lat(1, n);
        chk(n == 66, "R4", "reserved divider", n, 66);
        filt_code = 0; fdiv_code = 0;
        step(3);
        clear_flags();

        // R6 polarity
        edge_pol = 2'b01;
        cmp_raw = 0; step(5);
        chk(irq_flag == 0, "R6", "rise-only ignores fall", irq_flag, 0);
        cmp_raw = 1; step(5);
        chk(irq_flag == 1, "R6", "rise-only counts rise", irq_flag, 1);
        clear_flags();
        edge_pol = 2'b10;
        cmp_raw = 0; step(5);
        chk(irq_flag == 1, "R6", "fall-only counts fall", irq_flag, 1);
        clear_flags();
        cmp_raw = 1; step(5);
        chk(irq_flag == 0, "R6", "fall-only ignores rise", irq_flag, 0);
        edge_pol = 2'b11;
        cmp_raw = 0; step(5); cmp_raw = 1; step(5);
        chk(irq_flag == 0 && wake_flag == 0, "R6", "reserved polarity", irq_flag, 0);
        edge_pol = 2'b00;

        // R7 set wins over a held clear
        clr_irq = 1;
        cmp_raw = 0;
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            step(1);
            if (irq_flag) seen = 1;
        end
        clr_irq = 0;
        chk(seen, "R7", "set wins over clear", seen, 1);
        step(2);
        chk(irq_flag == 0, "R7", "clear after set", irq_flag, 0);

        // R8 request gating
        irq_en = 0;
        cmp_raw = 1; step(5);
        chk(irq_flag == 1 && irq == 0, "R8", "irq masked", irq, 0);
        irq_en = 1; step(1);
        chk(irq == 1, "R8", "irq unmasked", irq, 1);

        // R9 wake enable
        clear_flags();
        wake_en = 0;
        cmp_raw = 0; step(5);
        chk(wake_flag == 0, "R9", "wake disabled", wake_flag, 0);
        chk(irq_flag == 1, "R7", "flag still set", irq_flag, 1);
        wake_en = 1;

        // R10 disable
        ch_en = 0; cmp_raw = 1; step(1);
        chk(comp_status == 0 && pin_out == 0, "R10", "outputs off when disabled", pin_out, 0);
        step(4);
        chk(irq_flag == 1, "R7", "flag kept while disabled", irq_flag, 1);
        clear_flags();

        // R11 re-enable without spurious edge
        ch_en = 1; step(10);
        chk(irq_flag == 0, "R11", "no edge on enable", irq_flag, 0);
        chk(comp_status == 1, "R11", "level adopted", comp_status, 1);
        ch_en = 0; cmp_raw = 0; inv_en = 1; step(3);
        ch_en = 1; step(10);
        chk(irq_flag == 0, "R11", "no edge on inverted enable", irq_flag, 0);
        chk(comp_status == 1, "R11", "inverted level adopted", comp_status, 1);
        cmp_raw = 1; step(5);
        chk(irq_flag == 1, "R11", "later edge counted", irq_flag, 1);
        inv_en = 0;
        clear_flags();

        // Mixed random traffic checked by the reference model
        for (int blk = 0; blk < 20; blk++) begin
            filt_code = 3'($urandom_range(0, 7));
            fdiv_code = 2'($urandom_range(0, 3));
            edge_pol  = 2'($urandom_range(0, 3));
            pin_sel   = 1'($urandom_range(0, 1));
            inv_en    = 1'($urandom_range(0, 1));
            irq_en    = 1'($urandom_range(0, 1));
            wake_en   = 1'($urandom_range(0, 1));
            ch_en     = ($urandom_range(0, 7) != 0);
            for (int k = 0; k < 200; k++) begin
                if ($urandom_range(0, 9) == 0) cmp_raw = ~cmp_raw;
                clr_irq  = ($urandom_range(0, 30) == 0);
                clr_wake = ($urandom_range(0, 30) == 0);
                step(1);
            end
        end
        clr_irq = 0; clr_wake = 0;
        step(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule